// File: doc/BRIEF.md
# Flash Toggle-Bit Status Poller

This block decides when a program or erase job running inside a parallel NOR flash has finished. Once the job has been launched elsewhere, a start pulse hands the poller an address and a time budget. The poller then reads that address in back-to-back pairs. Bit 6 of the data word flips on every read while the device is busy. When two reads in a row return the same bit 6, the job is done. Bit 5 is the device's own time-limit flag. When bit 5 is raised, the poller reads one more pair before it declares a device error, because the job may have finished between the two pairs.

An optional wait on the device's ready/busy line can come before polling. That line passes through a two-flop synchroniser. Elapsed time is counted in units of `PRESC` clock cycles, and the poller checks it against the budget before each read pair. It reports one 2-bit outcome with a one-cycle `done_o` strobe. The outcome is held until the next start. Reads use a request/valid handshake: `rd_req_o` stays high until the memory side returns `rd_valid_i` together with the data.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset the block is idle: `busy_o`=0, `rd_req_o`=0, `done_o`=0 and `result_o`=00.
- R2: `start_i` is accepted only while idle. On acceptance it latches `addr_i`, `timeout_i` and `use_rb_i`. A start pulse while busy has no effect on the address being read or on the outcome.
- R3: Each read holds `rd_req_o` high until `rd_valid_i` arrives. Every read of a job targets the latched address.
- R4: If bit 6 has the same value in both reads of a pair, the job ends with `result_o`=01 (success).
- R5: If bit 6 differs and bit 5 of the pair's first read is 0, polling continues with another timeout check and another pair.
- R6: If bit 6 differs and bit 5 of the first read is 1, an extra pair follows at once. That pair gives success if bit 6 is stable. It gives `result_o`=10 (device error) if bit 6 still differs and its first read again has bit 5 = 1. Otherwise polling resumes.
- R7: A time budget of 0 ends the job with `result_o`=11 (timeout) and issues no read. Without the ready wait, `done_o` comes two cycles after the accepting edge.
- R8: For a nonzero budget T below all-ones, the block checks elapsed units (clock cycles / `PRESC`, counted from the accepting edge) before each pair. It ends with 11 once elapsed ≥ T.
- R9: An all-ones budget never expires, even after the elapsed counter saturates.
- R10: With the ready wait enabled, no read is issued until the synchronised `rb_i` is seen high. The budget also applies during this wait. With the wait disabled, `rb_i` has no effect.
- R11: `done_o` is a one-cycle pulse that comes with the final `result_o`. `result_o` reads 00 while a job runs and holds its outcome until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a polling job (sampled when idle) |
| addr_i | input | AW | Address to poll |
| timeout_i | input | TW | Budget in units of PRESC cycles; 0 = immediate, all-ones = unlimited |
| use_rb_i | input | 1 | Wait for the ready line before polling |
| rb_i | input | 1 | Device ready/busy line, high = ready (asynchronous) |
| rd_req_o | output | 1 | Read request, held until valid |
| rd_addr_o | output | AW | Read address |
| rd_valid_i | input | 1 | Read data valid, completes the pending request |
| rd_data_i | input | DW | Read data word |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse when the outcome is written |
| result_o | output | 2 | 00 running/none, 01 success, 10 device error, 11 timeout |

## Verification
The bench builds the poller with AW=8, DW=8, TW=6 and PRESC=4. A 6-bit budget saturates at 63 units, or 252 cycles. A device that takes 80 read pairs (about 400 cycles) therefore proves that an all-ones budget never expires. Every budget from 1 to 6 can be swept against a device that never completes, and the timeout cycle is checked against T·4. A small model of the device sweeps completion after 0 to 5 pairs against a sticky or a one-pair flag rising at each pair index from 0 to 5. This covers every placement of the extra pair relative to completion: before it, coinciding with it and after it.

// File: rtl/tpoll_pkg.sv
package tpoll_pkg;
  localparam int TGL_BIT = 6;
  localparam int LIM_BIT = 5;

  typedef enum logic [1:0] {
    RES_RUN  = 2'b00,
    RES_OK   = 2'b01,
    RES_FAIL = 2'b10,
    RES_TMO  = 2'b11
  } res_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RBWAIT,
    S_CHECK,
    S_RD1,
    S_RD2
  } st_e;
endpackage

// File: rtl/tpoll_sync.sv
module tpoll_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr <= '0;
    else         sr <= {sr[STAGES-2:0], d_i};
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/tpoll_timer.sv
module tpoll_timer #(
  parameter int TW    = 16,
  parameter int PRESC = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PW-1:0] pcnt;
  logic [TW-1:0] units;
  logic          wrap;

  assign wrap = (pcnt == PW'(PRESC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt  <= '0;
      units <= '0;
    end else if (clr_i) begin
      pcnt  <= '0;
      units <= '0;
    end else begin
      pcnt <= wrap ? '0 : pcnt + 1'b1;
      if (wrap && units != '1) units <= units + 1'b1;
    end
  end

  // all-ones budget never expires; zero expires at once
  assign expired_o = (limit_i == '0) || ((limit_i != '1) && (units >= limit_i));

  // R8
  units_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> units >= $past(units));
endmodule

// File: rtl/tpoll_fsm.sv
module tpoll_fsm
  import tpoll_pkg::*;
#(
  parameter int AW = 24,
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          use_rb_i,
  input  logic          rb_sync_i,
  input  logic          expired_i,
  input  logic          rd_valid_i,
  input  logic          tgl_i,
  input  logic          lim_i,
  output logic          clr_o,
  output logic [TW-1:0] limit_o,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  st_e           st;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] lim_q;
  logic          d1_tgl, d1_lim, retry_q, done_q;
  res_e          res_q;
  logic          accept;

  assign accept = start_i && (st == S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      lim_q   <= '0;
      d1_tgl  <= 1'b0;
      d1_lim  <= 1'b0;
      retry_q <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_RUN;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          addr_q  <= addr_i;
          lim_q   <= timeout_i;
          retry_q <= 1'b0;
          res_q   <= RES_RUN;
          st      <= use_rb_i ? S_RBWAIT : S_CHECK;
        end
        S_RBWAIT: begin
          if (expired_i) begin
            res_q <= RES_TMO; done_q <= 1'b1; st <= S_IDLE;
          end else if (rb_sync_i) begin
            st <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (expired_i) begin
            res_q <= RES_TMO; done_q <= 1'b1; st <= S_IDLE;
          end else begin
            st <= S_RD1;
          end
        end
        S_RD1: if (rd_valid_i) begin
          d1_tgl <= tgl_i;
          d1_lim <= lim_i;
          st     <= S_RD2;
        end
        S_RD2: if (rd_valid_i) begin
          if (d1_tgl == tgl_i) begin
            res_q <= RES_OK; done_q <= 1'b1; st <= S_IDLE;
          end else if (retry_q) begin
            retry_q <= 1'b0;
            if (d1_lim) begin
              res_q <= RES_FAIL; done_q <= 1'b1; st <= S_IDLE;
            end else begin
              st <= S_CHECK;
            end
          end else if (d1_lim) begin
            retry_q <= 1'b1;   // confirm pair, no timeout check
            st      <= S_RD1;
          end else begin
            st <= S_CHECK;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign clr_o     = accept;
  assign limit_o   = lim_q;
  assign rd_req_o  = (st == S_RD1) || (st == S_RD2);
  assign rd_addr_o = addr_q;
  assign busy_o    = (st != S_IDLE);
  assign done_o    = done_q;
  assign result_o  = res_q;

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_valid_i |=> rd_req_o);
  // R2
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(rd_addr_o));
  // R11
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(result_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  run_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> result_o == RES_RUN);
  // R7
  tmo_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !use_rb_i && timeout_i == '0 |=> ##1 (done_o && result_o == RES_TMO));
endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
  import tpoll_pkg::*;
#(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int TW    = 16,
  parameter int PRESC = 50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic [TW-1:0] timeout_i,
  input  logic          use_rb_i,
  input  logic          rb_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  logic          rb_sync, clr, expired;
  logic [TW-1:0] limit;
  logic          data_unused;

  assign data_unused = ^rd_data_i;

  tpoll_sync #(.STAGES(2)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rb_i), .q_o(rb_sync)
  );

  tpoll_timer #(.TW(TW), .PRESC(PRESC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .limit_i(limit), .expired_o(expired)
  );

  tpoll_fsm #(.AW(AW), .TW(TW)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .start_i(start_i), .addr_i(addr_i), .timeout_i(timeout_i), .use_rb_i(use_rb_i),
    .rb_sync_i(rb_sync), .expired_i(expired),
    .rd_valid_i(rd_valid_i), .tgl_i(rd_data_i[TGL_BIT]), .lim_i(rd_data_i[LIM_BIT]),
    .clr_o(clr), .limit_o(limit),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
  );

  // R10
  idle_noreq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> busy_o);
endmodule

// File: tb/sim_nor_toggle_poller.sv
module sim_nor_toggle_poller;
  localparam int AW = 8, DW = 8, TW = 6, PRESC = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, start, use_rb, rb, rd_req, rd_valid, busy, done;
  logic [AW-1:0] addr, rd_addr, exp_addr;
  logic [TW-1:0] tmo;
  logic [DW-1:0] rd_data;
  logic [1:0]    result;

  int checks = 0, errors = 0;
  int rd_cnt = 0, base = 0, addr_bad = 0;
  int m_k = 0, m_e = 0, m_mode = 0;

  nor_toggle_poller #(.AW(AW), .DW(DW), .TW(TW), .PRESC(PRESC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr), .timeout_i(tmo),
    .use_rb_i(use_rb), .rb_i(rb), .rd_req_o(rd_req), .rd_addr_o(rd_addr),
    .rd_valid_i(rd_valid), .rd_data_i(rd_data), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  // device: bit6 alternates for pairs below m_k; bit5 sticky (mode 1) or one pair (mode 2) at m_e
  function automatic logic [DW-1:0] dev_data(int idx);
    int j = idx / 2;
    logic [DW-1:0] d = DW'(idx * 3) & 8'h9F;
    d[6] = (j < m_k) ? idx[0] : 1'b1;
    d[5] = (m_mode == 1) ? (j >= m_e) : (m_mode == 2) ? (j == m_e) : 1'b0;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (rd_req && !rd_valid) begin
      rd_valid <= 1'b1;
      rd_data  <= dev_data(rd_cnt - base);
      rd_cnt   <= rd_cnt + 1;
      if (rd_addr !== exp_addr) addr_bad <= addr_bad + 1;
    end else begin
      rd_valid <= 1'b0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic pulse_start(input logic rbe, input logic [AW-1:0] a, input int t);
    @(negedge clk);
    base = rd_cnt; exp_addr = a; addr = a; tmo = TW'(t); use_rb = rbe; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run(input logic rbe, input logic [AW-1:0] a, input int t,
                     output int res, output int reads, output int cyc);
    pulse_start(rbe, a, t);
    wait_done(cyc);
    res = result;
    reads = rd_cnt - base;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int res, reads, cyc, held;
    rst_n = 1'b0; start = 1'b0; use_rb = 1'b0; rb = 1'b1; addr = '0; tmo = '0; exp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 req", rd_req, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);

    // R4 R5 R6 sweep of completion point vs flag placement
    for (int mode = 0; mode < 3; mode++)
      for (int k = 0; k < 6; k++)
        for (int e = 0; e < 6; e++) begin
          int exp_res, exp_pairs;
          m_mode = mode; m_k = k; m_e = e;
          if (mode == 1 && e < k && e + 1 < k) begin
            exp_res = 2; exp_pairs = e + 2;
          end else begin
            exp_res = 1; exp_pairs = k + 1;
          end
          run(1'b0, AW'(k * 16 + e * 2 + mode), 63, res, reads, cyc);
          chk((mode == 0) ? "R4 result" : "R6 result", res, exp_res);
          chk((mode == 0) ? "R5 reads" : "R6 reads", reads, 2 * exp_pairs);
          // R11 outcome held, strobe gone
          repeat (3) @(negedge clk);
          chk("R11 hold", result, exp_res);
          chk("R11 pulse", done, 0);
        end
    chk("R3 address of every read", addr_bad, 0);

    // R7 zero budget
    m_mode = 0; m_k = 3;
    run(1'b0, 8'h5A, 0, res, reads, cyc);
    chk("R7 result", res, 3);
    chk("R7 reads", reads, 0);
    chk("R7 latency", cyc, 2);

    // R8 budgets against a device that never completes
    m_k = 100000;
    for (int t = 1; t <= 6; t++) begin
      run(1'b0, AW'(t), t, res, reads, cyc);
      chk("R8 result", res, 3);
      chk_rng("R8 latency", cyc, t * PRESC, t * PRESC + 8);
    end

    // R9 all-ones budget outlasts saturation (80 pairs ~ 400 cycles > 252)
    m_k = 80;
    run(1'b0, 8'hC3, 63, res, reads, cyc);
    chk("R9 result", res, 1);
    chk("R9 reads", reads, 162);

    // R10 ready wait: no reads while rb low
    m_k = 2; rb = 1'b0;
    pulse_start(1'b1, 8'h33, 63);
    repeat (12) @(negedge clk);
    chk("R10 no reads before ready", rd_cnt - base, 0);
    chk("R10 no request before ready", rd_req, 0);
    rb = 1'b1;
    wait_done(cyc);
    chk("R10 result after ready", result, 1);
    chk("R10 reads after ready", rd_cnt - base, 6);

    // R10 budget applies during ready wait
    rb = 1'b0;
    run(1'b1, 8'h44, 3, res, reads, cyc);
    chk("R10 wait timeout", res, 3);
    chk("R10 wait timeout reads", reads, 0);

    // R10 rb ignored when wait disabled
    m_k = 1;
    run(1'b0, 8'h45, 63, res, reads, cyc);
    chk("R10 rb ignored result", res, 1);
    chk("R10 rb ignored reads", reads, 4);
    rb = 1'b1;

    // R2 start while busy ignored
    m_k = 6; held = addr_bad;
    pulse_start(1'b0, 8'h21, 63);
    repeat (3) @(negedge clk);
    addr = 8'hEE; tmo = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R2 result", result, 1);
    chk("R2 reads", rd_cnt - base, 14);
    chk("R2 address kept", addr_bad - held, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule